// File: doc/BRIEF.md
# ADC Calibration Correction Datapath

This block sits behind a delta-sigma converter's decimation filter and turns each raw conversion result into a corrected output code. Each sample goes through four steps in a fixed order. The self-calibration offset is subtracted and the self-calibration gain is applied. The system offset is then subtracted and the system gain is applied. Last comes a power-of-two digital gain, followed by saturation to the output range. Each of the four coefficients can be bypassed on its own through a control byte. The same byte holds the digital gain code.

Coefficients are loaded through a simple write port, one word per clock, with a 2-bit select. A polarity input chooses between unsigned (unipolar) and two's-complement (bipolar) coding, for both the raw input and the clamped output. Samples enter and leave through valid/ready handshakes. The datapath takes one sample per clock, delivers it four clocks later, and freezes as a whole while the consumer withholds ready.

Top module: `adc_cal_correct`

## Requirements
- R1: After reset the offsets are 0, the gains are unity (2^22), and the control byte is 0x00. Every accepted sample then comes out equal to its raw code with the overflow flag low.
- R2: The self offset (coefficient select 0, 24-bit two's complement) is subtracted from the raw value. It counts as zero while control bit 1 is 1.
- R3: The self gain (select 1, 24-bit unsigned, unity at 2^22) multiplies the value. The product is floored after the right shift by 22. It counts as unity while control bit 2 is 1.
- R4: The system offset (select 2) is subtracted after the self gain. It counts as zero while control bit 3 is 1.
- R5: The system gain (select 3) multiplies the value last among the calibration steps, with the same flooring. It counts as unity while control bit 4 is 1.
- R6: The corrections apply in this order: self offset, self gain, system offset, system gain. Each product is floored before the next step.
- R7: Control bits 7:5 hold a code k. The fully calibrated value is multiplied by 2^k (1 to 128) before clamping.
- R8: With bipolar = 1, the input is taken as two's complement, and results outside -524288..524287 clip to the nearer extreme with out_ovf = 1.
- R9: With bipolar = 0, the input is taken as unsigned, and results outside 0..1048575 clip to 0 or 1048575 with out_ovf = 1.
- R10: A write to the control byte reads back on ctrl_rdata from the next clock on, with bits 7:1 as written and bit 0 always 0.
- R11: A coefficient write takes effect on samples accepted after the write clock. Select codes 0..3 address self offset, self gain, system offset and system gain.
- R12: in_ready equals (not out_valid) or out_ready. The block accepts one sample per clock, and while out_valid is high and out_ready is low, out_data, out_ovf and out_valid hold.
- R13: A sample accepted at clock edge n appears on the output after edge n+3 (four register stages), provided out_ready stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bipolar | input | 1 | 1: two's-complement coding, 0: unsigned coding |
| in_valid | input | 1 | Raw sample present |
| in_ready | output | 1 | Block can take a sample this clock |
| in_data | input | 20 | Raw conversion result |
| out_valid | output | 1 | Corrected sample present |
| out_ready | input | 1 | Consumer takes the sample this clock |
| out_data | output | 20 | Corrected, gained and clamped code |
| out_ovf | output | 1 | The result was clipped |
| coef_wr | input | 1 | Coefficient write strobe |
| coef_sel | input | 2 | Coefficient select (0 self offset, 1 self gain, 2 system offset, 3 system gain) |
| coef_wdata | input | 24 | Coefficient write value |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte value |
| ctrl_rdata | output | 8 | Control byte readback |

## Verification
The assertions assume that the coefficients, the control byte and the polarity input stay unchanged while any sample is inside the four stages. Results are computed from the settings that hold while the sample travels, so a change mid-flight would mix old and new settings. The stimulus keeps within this: it reprograms only after the scoreboard queue has emptied and two idle clocks have passed, and it holds in_valid and in_data until in_ready is seen. The consumer's ready toggles from a pseudo-random sequence, which exercises the stall hold without breaking these assumptions.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

   localparam int CTRL_W = 8;
   localparam int DG_W   = 3;

   // coefficient select codes used by the write port
   typedef enum logic [1:0] {
      SEL_SELF_OFF  = 2'd0,
      SEL_SELF_GAIN = 2'd1,
      SEL_SYS_OFF   = 2'd2,
      SEL_SYS_GAIN  = 2'd3
   } coef_sel_e;

   // control byte layout; the bypass bits sit in a fixed order
   typedef struct packed {
      logic [DG_W-1:0] dgain;
      logic            skip_sys_gain;
      logic            skip_sys_off;
      logic            skip_self_gain;
      logic            skip_self_off;
      logic            rsv;
   } ctrl_t;

endpackage

// File: rtl/adc_cal_regs.sv
module adc_cal_regs
   import adc_cal_pkg::*;
#(
   parameter int COEF_W = 24,
   parameter int FRAC   = 22
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         coef_wr,
   input  logic [1:0]                   coef_sel,
   input  logic [COEF_W-1:0]            coef_wdata,
   input  logic                         ctrl_wr,
   input  logic [CTRL_W-1:0]            ctrl_wdata,
   output logic [CTRL_W-1:0]            ctrl_rdata,
   output logic [DG_W-1:0]              dgain,
   output logic [1:0]                   off_skip,
   output logic [1:0]                   gain_skip,
   output logic [1:0][COEF_W-1:0]       offs,
   output logic [1:0][COEF_W-1:0]       gains
);

   localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC;

   logic [COEF_W-1:0] coef_q [4];
   ctrl_t             ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coef_q[SEL_SELF_OFF]  <= '0;
         coef_q[SEL_SELF_GAIN] <= UNITY;
         coef_q[SEL_SYS_OFF]   <= '0;
         coef_q[SEL_SYS_GAIN]  <= UNITY;
      end else if (coef_wr) begin
         coef_q[coef_sel] <= coef_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= {ctrl_wdata[CTRL_W-1:1], 1'b0};
   end

   assign ctrl_rdata = ctrl_q;
   assign dgain      = ctrl_q.dgain;
   assign off_skip   = {ctrl_q.skip_sys_off,  ctrl_q.skip_self_off};
   assign gain_skip  = {ctrl_q.skip_sys_gain, ctrl_q.skip_self_gain};
   assign offs       = {coef_q[SEL_SYS_OFF],  coef_q[SEL_SELF_OFF]};
   assign gains      = {coef_q[SEL_SYS_GAIN], coef_q[SEL_SELF_GAIN]};

   AST_COEF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      coef_wr |=> coef_q[$past(coef_sel)] == $past(coef_wdata)); // R11
   AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> ctrl_rdata == {$past(ctrl_wdata[CTRL_W-1:1]), 1'b0}); // R10

endmodule

// File: rtl/adc_cal_stage.sv
module adc_cal_stage #(
   parameter int ACC_W  = 39,
   parameter int COEF_W = 24,
   parameter int FRAC   = 22
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    v_in,
   input  logic signed [ACC_W-1:0] d_in,
   input  logic [COEF_W-1:0]       offset,
   input  logic                    off_skip,
   input  logic [COEF_W-1:0]       gain,
   input  logic                    gain_skip,
   output logic                    v_out,
   output logic signed [ACC_W-1:0] d_out
);

   localparam int PROD_W = ACC_W + COEF_W + 1;

   logic signed [ACC_W-1:0]  off_x;
   logic signed [ACC_W-1:0]  diff;
   logic signed [PROD_W-1:0] diff_x;
   logic signed [PROD_W-1:0] gain_x;
   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W-1:0]  scaled;

   always_comb begin
      off_x  = off_skip ? '0 : {{(ACC_W-COEF_W){offset[COEF_W-1]}}, offset};
      diff   = d_in - off_x;
      diff_x = {{(PROD_W-ACC_W){diff[ACC_W-1]}}, diff};
      gain_x = {{(PROD_W-COEF_W){1'b0}}, gain};
      prod   = diff_x * gain_x;
      scaled = gain_skip ? diff : ACC_W'(prod >>> FRAC);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_out <= 1'b0;
         d_out <= '0;
      end else if (en) begin
         v_out <= v_in;
         d_out <= scaled;
      end
   end

   AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && v_in) |=> v_out); // R12
   AST_STAGE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(v_out) && $stable(d_out))); // R12

endmodule

// File: rtl/adc_cal_finish.sv
module adc_cal_finish
   import adc_cal_pkg::*;
#(
   parameter int ACC_W = 39,
   parameter int OUT_W = 20
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    v_in,
   input  logic signed [ACC_W-1:0] d_in,
   input  logic                    bipolar,
   input  logic [DG_W-1:0]         dgain,
   output logic                    v_out,
   output logic [OUT_W-1:0]        d_out,
   output logic                    ovf
);

   localparam logic signed [ACC_W-1:0] BI_HI  = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] BI_LO  = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
   localparam logic signed [ACC_W-1:0] UNI_HI = {{(ACC_W-OUT_W){1'b0}}, {OUT_W{1'b1}}};
   localparam logic [OUT_W-1:0] RAIL_BI_HI  = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] RAIL_BI_LO  = {1'b1, {(OUT_W-1){1'b0}}};

   // barrel shifter: one conditional stage per digital gain bit
   logic signed [ACC_W-1:0] sh [DG_W+1];
   assign sh[0] = d_in;
   for (genvar k = 0; k < DG_W; k++) begin : g_shift
      assign sh[k+1] = dgain[k] ? (sh[k] <<< (2**k)) : sh[k];
   end

   logic signed [ACC_W-1:0] hi, lo, clip;
   logic                    clip_ovf;

   always_comb begin
      hi       = bipolar ? BI_HI : UNI_HI;
      lo       = bipolar ? BI_LO : '0;
      clip     = sh[DG_W];
      clip_ovf = 1'b0;
      if (sh[DG_W] > hi) begin
         clip     = hi;
         clip_ovf = 1'b1;
      end else if (sh[DG_W] < lo) begin
         clip     = lo;
         clip_ovf = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_out <= 1'b0;
         d_out <= '0;
         ovf   <= 1'b0;
      end else if (en) begin
         v_out <= v_in;
         d_out <= OUT_W'(clip);
         ovf   <= clip_ovf;
      end
   end

   AST_OVF_AT_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (v_out && ovf) |-> (d_out == RAIL_BI_HI || d_out == RAIL_BI_LO ||
                          d_out == '0 || d_out == '1)); // R8

endmodule

// File: rtl/adc_cal_correct.sv
module adc_cal_correct
   import adc_cal_pkg::*;
#(
   parameter int OUT_W  = 20,
   parameter int COEF_W = 24,
   parameter int FRAC   = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bipolar,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [OUT_W-1:0]  in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [OUT_W-1:0]  out_data,
   output logic              out_ovf,
   input  logic              coef_wr,
   input  logic [1:0]        coef_sel,
   input  logic [COEF_W-1:0] coef_wdata,
   input  logic              ctrl_wr,
   input  logic [7:0]        ctrl_wdata,
   output logic [7:0]        ctrl_rdata
);

   localparam int WIDEST = (OUT_W > COEF_W) ? OUT_W : COEF_W;
   localparam int ACC_W  = WIDEST + 3 + 2 * (COEF_W - FRAC) + (2**DG_W);
   localparam int N_CAL  = 2;

   if (FRAC < 1 || COEF_W <= FRAC) begin : g_bad_frac
      $error("adc_cal_correct: FRAC must be at least 1 and below COEF_W");
   end
   if (OUT_W < 2) begin : g_bad_out
      $error("adc_cal_correct: OUT_W must be at least 2");
   end

   logic                    adv;
   logic [DG_W-1:0]         dgain;
   logic [1:0]              off_skip, gain_skip;
   logic [1:0][COEF_W-1:0]  offs, gains;

   assign adv      = !out_valid || out_ready;
   assign in_ready = adv;

   adc_cal_regs #(.COEF_W(COEF_W), .FRAC(FRAC)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .coef_wr    (coef_wr),
      .coef_sel   (coef_sel),
      .coef_wdata (coef_wdata),
      .ctrl_wr    (ctrl_wr),
      .ctrl_wdata (ctrl_wdata),
      .ctrl_rdata (ctrl_rdata),
      .dgain      (dgain),
      .off_skip   (off_skip),
      .gain_skip  (gain_skip),
      .offs       (offs),
      .gains      (gains)
   );

   // ingress register: widen the raw code by polarity
   logic                    v_c [N_CAL+1];
   logic signed [ACC_W-1:0] d_c [N_CAL+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_c[0] <= 1'b0;
         d_c[0] <= '0;
      end else if (adv) begin
         v_c[0] <= in_valid;
         d_c[0] <= bipolar ? {{(ACC_W-OUT_W){in_data[OUT_W-1]}}, in_data}
                           : {{(ACC_W-OUT_W){1'b0}}, in_data};
      end
   end

   // stage 0: self-calibration pair, stage 1: system pair
   for (genvar i = 0; i < N_CAL; i++) begin : g_cal
      adc_cal_stage #(.ACC_W(ACC_W), .COEF_W(COEF_W), .FRAC(FRAC)) u_stage (
         .clk       (clk),
         .rst_n     (rst_n),
         .en        (adv),
         .v_in      (v_c[i]),
         .d_in      (d_c[i]),
         .offset    (offs[i]),
         .off_skip  (off_skip[i]),
         .gain      (gains[i]),
         .gain_skip (gain_skip[i]),
         .v_out     (v_c[i+1]),
         .d_out     (d_c[i+1])
      );
   end

   adc_cal_finish #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_finish (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (adv),
      .v_in    (v_c[N_CAL]),
      .d_in    (d_c[N_CAL]),
      .bipolar (bipolar),
      .dgain   (dgain),
      .v_out   (out_valid),
      .d_out   (out_data),
      .ovf     (out_ovf)
   );

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ovf))); // R12
   AST_ACCEPT_REACHES_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> v_c[0]); // R13

endmodule

// File: tb/adc_cal_correct_bench.sv
module adc_cal_correct_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bipolar = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [19:0] in_data = '0;
   logic        out_valid;
   logic        out_ready;
   logic [19:0] out_data;
   logic        out_ovf;
   logic        coef_wr = 1'b0;
   logic [1:0]  coef_sel = '0;
   logic [23:0] coef_wdata = '0;
   logic        ctrl_wr = 1'b0;
   logic [7:0]  ctrl_wdata = '0;
   logic [7:0]  ctrl_rdata;

   always #2 clk = ~clk;

   adc_cal_correct u_adc_cal_correct (
      .clk(clk), .rst_n(rst_n), .bipolar(bipolar),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_ovf(out_ovf),
      .coef_wr(coef_wr), .coef_sel(coef_sel), .coef_wdata(coef_wdata),
      .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata)
   );

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [19:0] d;
      bit          ovf;
      string       tag;
   } exp_t;
   exp_t q[$];

   // mirrored settings for the reference model
   longint   m_so = 0, m_yo = 0;
   longint   m_sg = 64'd4194304, m_yg = 64'd4194304;
   logic [7:0] m_ctrl = 8'h00;

   // consumer ready: pseudo-random or forced
   logic        rnd_en = 1'b0;
   logic        force_ready = 1'b1;
   logic [15:0] lfsr = 16'hACE1;
   initial out_ready = 1'b1;
   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = rnd_en ? (lfsr[0] | lfsr[3]) : force_ready;
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   function automatic exp_t model(input logic [19:0] raw, input string tag);
      longint v, hi, lo;
      exp_t e;
      v = bipolar ? longint'($signed(raw)) : longint'({44'd0, raw});
      if (!m_ctrl[1]) v = v - m_so;
      if (!m_ctrl[2]) v = (v * m_sg) >>> 22;
      if (!m_ctrl[3]) v = v - m_yo;
      if (!m_ctrl[4]) v = (v * m_yg) >>> 22;
      v = v * (longint'(1) << m_ctrl[7:5]);
      hi = bipolar ? 64'sd524287 : 64'sd1048575;
      lo = bipolar ? -64'sd524288 : 64'sd0;
      e.ovf = 1'b0;
      if (v > hi) begin v = hi; e.ovf = 1'b1; end
      else if (v < lo) begin v = lo; e.ovf = 1'b1; end
      e.d = v[19:0];
      e.tag = tag;
      return e;
   endfunction

   // monitor: pops expected items as results are taken
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (q.size() == 0) begin
            check(1'b0, "R12 unexpected output", longint'(out_data), 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(out_data === e.d, e.tag, longint'(out_data), longint'(e.d));
            check(out_ovf === e.ovf, {e.tag, " flag"}, longint'(out_ovf), longint'(e.ovf));
         end
      end
   end

   task automatic send(input logic [19:0] raw, input string tag);
      q.push_back(model(raw, tag));
      in_data  = raw;
      in_valid = 1'b1;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic drain;
      while (q.size() != 0) @(posedge clk);
      repeat (2) @(posedge clk);
      #1;
   endtask

   task automatic write_coef(input logic [1:0] sel, input logic [23:0] val);
      coef_sel = sel; coef_wdata = val; coef_wr = 1'b1;
      @(posedge clk); #1;
      coef_wr = 1'b0;
      case (sel)
         2'd0: m_so = longint'($signed(val));
         2'd1: m_sg = longint'({40'd0, val});
         2'd2: m_yo = longint'($signed(val));
         default: m_yg = longint'({40'd0, val});
      endcase
   endtask

   task automatic write_ctrl(input logic [7:0] val);
      ctrl_wdata = val; ctrl_wr = 1'b1;
      @(posedge clk); #1;
      ctrl_wr = 1'b0;
      m_ctrl = {val[7:1], 1'b0};
   endtask

   initial begin
      #(4 * 150000);
      check(1'b0, "watchdog expired", 0, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // reset state (R1, R10, R12)
      check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
      check(ctrl_rdata == 8'h00, "R10 ctrl after reset", longint'(ctrl_rdata), 0);
      check(in_ready == 1'b1, "R12 in_ready after reset", longint'(in_ready), 1);
      @(posedge clk); #1;

      // R1: identity after reset, both polarities
      send(20'h00000, "R1 zero");
      send(20'd12345, "R1 positive");
      send(20'hFFFFF, "R1 minus one");
      send(20'h7FFFF, "R1 max");
      send(20'h80000, "R1 min");
      drain();
      bipolar = 1'b0;
      send(20'hFFFFF, "R1 unipolar top");
      send(20'd777, "R1 unipolar mid");
      drain();
      bipolar = 1'b1;

      // R13: latency of four register stages
      force_ready = 1'b1;
      q.push_back(model(20'd4242, "R13 latency data"));
      in_data = 20'd4242; in_valid = 1'b1;
      @(posedge clk); #1;
      in_valid = 1'b0;
      for (int c = 1; c <= 4; c++) begin
         @(negedge clk);
         check(out_valid == (c == 4), "R13 valid timing", longint'(out_valid), longint'(c == 4));
      end
      drain();

      // R2: self offset and its bypass (control bit 1)
      write_coef(2'd0, 24'd1000);
      send(20'd5000, "R2 self offset");
      send(20'hFFC18, "R2 self offset negative");
      drain();
      write_ctrl(8'h02);
      send(20'd5000, "R2 self offset bypassed");
      drain();
      write_ctrl(8'h00);
      write_coef(2'd0, 24'd0);

      // R3: self gain 1.5 with floor, and its bypass (bit 2)
      write_coef(2'd1, 24'h600000);
      send(20'd1001, "R3 self gain");
      send(20'hFFFFD, "R3 self gain floor");
      drain();
      write_ctrl(8'h04);
      send(20'd1001, "R3 self gain bypassed");
      drain();
      write_ctrl(8'h00);
      write_coef(2'd1, 24'h400000);

      // R4: system offset and bypass (bit 3)
      write_coef(2'd2, 24'hFFFF38);
      send(20'd300, "R4 system offset");
      drain();
      write_ctrl(8'h08);
      send(20'd300, "R4 system offset bypassed");
      drain();
      write_ctrl(8'h00);
      write_coef(2'd2, 24'd0);

      // R5: system gain 0.75 and bypass (bit 4)
      write_coef(2'd3, 24'h300000);
      send(20'd1001, "R5 system gain");
      send(20'hFFF00, "R5 system gain negative");
      drain();
      write_ctrl(8'h10);
      send(20'd1001, "R5 system gain bypassed");
      drain();
      write_ctrl(8'h00);

      // R6 R11: all four coefficients active, order matters
      write_coef(2'd0, 24'd100);
      write_coef(2'd1, 24'h800000);
      write_coef(2'd2, 24'd50);
      write_coef(2'd3, 24'h300000);
      send(20'd1000, "R6 R11 full chain");
      send(20'hFFC00, "R6 R11 full chain negative");
      send(20'd3, "R6 R11 full chain small");
      drain();
      write_coef(2'd1, 24'h400000);
      write_coef(2'd2, 24'd0);
      write_coef(2'd3, 24'h400000);

      // R7: every digital gain code, after the self offset of 100
      for (int k = 0; k < 8; k++) begin
         write_ctrl({k[2:0], 5'b00000});
         send(20'd150, "R7 digital gain");
         send(20'hFFFCE, "R7 digital gain negative");
         drain();
      end
      write_coef(2'd0, 24'd0);

      // R8: bipolar saturation at both rails
      write_ctrl(8'hE0);
      send(20'd10000, "R8 clip high");
      send(20'hFD8F0, "R8 clip low");
      send(20'd4095, "R8 just inside");
      drain();
      write_ctrl(8'h00);
      write_coef(2'd1, 24'hFFFFFF);
      send(20'h7FFFF, "R8 gain pushes over");
      drain();
      write_coef(2'd1, 24'h400000);

      // R9: unipolar saturation at both rails
      bipolar = 1'b0;
      write_coef(2'd0, 24'd10);
      send(20'd5, "R9 clip to zero");
      send(20'd20, "R9 inside");
      drain();
      write_coef(2'd0, 24'hFFFF38);
      send(20'hFFFFF, "R9 clip to top");
      drain();
      write_coef(2'd0, 24'd0);
      bipolar = 1'b1;

      // R10: reserved bit reads 0
      write_ctrl(8'hFF);
      @(negedge clk);
      check(ctrl_rdata == 8'hFE, "R10 readback", longint'(ctrl_rdata), 64'hFE);
      @(posedge clk); #1;
      write_ctrl(8'h5B);
      @(negedge clk);
      check(ctrl_rdata == 8'h5A, "R10 readback pattern", longint'(ctrl_rdata), 64'h5A);
      @(posedge clk); #1;
      write_ctrl(8'h00);

      // R12: output holds while the consumer stalls
      force_ready = 1'b0;
      @(posedge clk); #1;
      send(20'd31337, "R12 stalled item");
      @(negedge clk);
      while (!out_valid) @(negedge clk);
      begin
         logic [19:0] held;
         held = out_data;
         check(in_ready == 1'b0, "R12 in_ready during stall", longint'(in_ready), 0);
         for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check(out_valid && out_data == held, "R12 hold", longint'(out_data), longint'(held));
         end
      end
      @(posedge clk); #1;
      force_ready = 1'b1;
      drain();

      // R12: streaming under a random consumer
      write_coef(2'd0, 24'd37);
      write_coef(2'd3, 24'h480000);
      write_ctrl(8'h20);
      rnd_en = 1'b1;
      for (int n = 0; n < 64; n++) begin
         send(20'((n * 7919) ^ (n << 13)), "R12 stream");
      end
      drain();
      rnd_en = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule